// File: doc/BRIEF.md
# Sleep Mode Entry/Exit Sequencer

This block sequences a memory device into and out of a low-power sleep state. The sleep request arrives asynchronously and active high; a low or undriven request means normal operation. The request first passes a synchroniser. The state machine then walks through a fixed-length entry window before it reports the device as asleep, and through a fixed-length recovery window before it reports the device as awake again. A request that reverses in the middle of either window sends the machine back to the stable state it came from.

While a transition or the sleep state is in progress, the block tells the access cycle controller to refuse new accesses and forces the data bus to high impedance. Stored data is not touched by this block. Two misuses of the protocol are recorded in a sticky flag that only reset clears: an access start strobe seen while the device is not fully awake, and a device that is still selected or bursting while a synchronised sleep request is present.

Top module: `sleep_seq`

## Requirements
- R1: The sleep request passes through two synchronising flops. A request level applied before clock edge k reaches `inhibit_o` after edge k+1 and first moves the state machine out of its stable state on edge k+2.
- R2: Entry takes two clock cycles. The machine spends exactly two cycles in the entry window (`bus_hiz_o`=1, `asleep_o`=0) and then raises `asleep_o`.
- R3: Exit takes two clock cycles. After the synchronised request drops, the machine spends exactly two cycles in the recovery window (`asleep_o`=0, `bus_hiz_o`=1) and then lowers `bus_hiz_o`.
- R4: If the synchronised request drops during the entry window, the next state is awake. If it rises again during the recovery window, the next state is asleep.
- R5: `inhibit_o` is high whenever the machine is not in the awake state, and also whenever the synchronised request is high.
- R6: `bus_hiz_o` is high in the entry window, the asleep state and the recovery window, and is low in the awake state.
- R7: A start strobe (`start_i`=1) sampled while the machine is not in the awake state sets `violation_o` on the following clock edge. A start strobe while awake does not set it.
- R8: `sel_i`=1 sampled while the synchronised request is high sets `violation_o` on the following clock edge. `sel_i`=1 with the request low does not set it.
- R9: Once set, `violation_o` stays high until `rst_ni` is asserted.
- R10: While `rst_ni` is low and after it is released, before any request arrives, the machine is awake and `asleep_o`, `inhibit_o`, `bus_hiz_o` and `violation_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high |
| sel_i | input | 1 | Device selected or burst in progress |
| start_i | input | 1 | Access start strobe from either address strobe |
| asleep_o | output | 1 | Device is in the sleep state |
| inhibit_o | output | 1 | Cycle controller must refuse new accesses |
| bus_hiz_o | output | 1 | Force the data bus to high impedance |
| violation_o | output | 1 | Sticky protocol violation flag |

## Verification
The embedded assertions check on every cycle that the asleep state is reached only after two entry cycles, that the awake state is reached only after two recovery cycles, that a request dropping during entry returns the machine to awake, that a start strobe outside the awake state raises the flag, and that the flag never falls without reset. The exact two-edge synchroniser latency, the reversal from recovery back to sleep, and the cases where a strobe or selection must leave the flag low only show up in the bench's scenarios. Those scenarios are compared on every clock against a behavioural model.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE    = 2'd0,
    ST_ENTERING = 2'd1,
    ST_ASLEEP   = 2'd2,
    ST_EXITING  = 2'd3
  } slp_state_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import sleep_pkg::*;
#(
  parameter int ENTER_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  output slp_state_e state_o
);
  localparam int MAX_CYC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ENTER_LAST = CNT_W'(ENTER_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYC - 1);

  slp_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_AWAKE: if (req_i) begin
        state_d = ST_ENTERING;
        cnt_d   = '0;
      end
      ST_ENTERING: begin
        if (!req_i)                  state_d = ST_AWAKE;
        else if (cnt_q == ENTER_LAST) state_d = ST_ASLEEP;
        else                         cnt_d   = cnt_q + 1'b1;
      end
      ST_ASLEEP: if (!req_i) begin
        state_d = ST_EXITING;
        cnt_d   = '0;
      end
      ST_EXITING: begin
        if (req_i)                   state_d = ST_ASLEEP;
        else if (cnt_q == EXIT_LAST) state_d = ST_AWAKE;
        else                         cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  // R2: asleep is entered from the entry window only after its second cycle
  p_enter_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ASLEEP && $past(state_q) == ST_ENTERING) |-> $past(state_q, 2) == ST_ENTERING);

  // R3: awake is re-entered from recovery only after its second cycle
  p_exit_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AWAKE && $past(state_q) == ST_EXITING) |-> $past(state_q, 2) == ST_EXITING);

  // R4: a dropped request during entry aborts back to awake
  p_enter_abort_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENTERING && !req_i) |=> state_q == ST_AWAKE);
endmodule

// File: rtl/slp_viol.sv
module slp_viol
  import sleep_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  slp_state_e state_i,
  input  logic       req_i,
  input  logic       sel_i,
  input  logic       start_i,
  output logic       viol_o
);
  logic viol_q, hit;

  assign hit = (start_i && state_i != ST_AWAKE) || (sel_i && req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  viol_q <= 1'b0;
    else if (hit) viol_q <= 1'b1;
  end

  assign viol_o = viol_q;

  p_start_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_i != ST_AWAKE) |=> viol_q);

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_q |=> viol_q);
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTER_CYC   = 2,
  parameter int EXIT_CYC    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic sel_i,
  input  logic start_i,
  output logic asleep_o,
  output logic inhibit_o,
  output logic bus_hiz_o,
  output logic violation_o
);
  logic       req_s;
  slp_state_e state;

  slp_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sleep_req_i),
    .q_o   (req_s)
  );

  slp_fsm #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) i_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_s),
    .state_o(state)
  );

  slp_viol i_viol (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_i(state),
    .req_i  (req_s),
    .sel_i  (sel_i),
    .start_i(start_i),
    .viol_o (violation_o)
  );

  assign asleep_o  = (state == ST_ASLEEP);
  assign bus_hiz_o = (state != ST_AWAKE);
  assign inhibit_o = (state != ST_AWAKE) || req_s;

  // R6: the bus may only be released once fully awake
  p_hiz_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o |-> bus_hiz_o && inhibit_o);
endmodule

// File: tb/test_sleep_seq.sv
module test_sleep_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, sel = 1'b0, start = 1'b0;
  logic asleep, inhibit, hiz, viol;
  int total = 0, bad = 0;

  // behavioural model: 0 awake, 1 entering, 2 asleep, 3 exiting
  int m_s1, m_req, m_state, m_cnt, m_viol;

  always #10 clk = ~clk;

  sleep_seq i_sleep_seq (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .sel_i(sel),
    .start_i(start), .asleep_o(asleep), .inhibit_o(inhibit),
    .bus_hiz_o(hiz), .violation_o(viol)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_req = 0; m_state = 0; m_cnt = 0; m_viol = 0;
    end else begin
      if ((start && m_state != 0) || (sel && m_req != 0)) m_viol = 1;
      case (m_state)
        0: if (m_req != 0) begin m_state = 1; m_cnt = 0; end
        1: if (m_req == 0) m_state = 0;
           else if (m_cnt == 1) m_state = 2;
           else m_cnt++;
        2: if (m_req == 0) begin m_state = 3; m_cnt = 0; end
        default: if (m_req != 0) m_state = 2;
           else if (m_cnt == 1) m_state = 0;
           else m_cnt++;
      endcase
      m_req = m_s1;
      m_s1 = int'(sleep_req);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk(int'(asleep) == (m_state == 2 ? 1 : 0), "R2 asleep_o vs model", int'(asleep), m_state == 2);
    chk(int'(inhibit) == ((m_state != 0 || m_req != 0) ? 1 : 0), "R5 inhibit_o vs model",
        int'(inhibit), (m_state != 0 || m_req != 0));
    chk(int'(hiz) == (m_state != 0 ? 1 : 0), "R6 bus_hiz_o vs model", int'(hiz), m_state != 0);
    chk(int'(viol) == m_viol, "R7 violation_o vs model", int'(viol), m_viol);
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_model();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sleep_req = 1'b0; sel = 1'b0; start = 1'b0;
    @(negedge clk);
    chk(!asleep && !inhibit && !hiz && !viol, "R10 outputs low in reset",
        {asleep, inhibit, hiz, viol}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    tick(3);
    chk({asleep, inhibit, hiz, viol} == 4'b0, "R10 idle after reset", {asleep, inhibit, hiz, viol}, 0);

    // R1 / R2: full entry
    sleep_req = 1'b1;
    tick(1); chk(inhibit == 1'b0, "R1 inhibit after one edge", inhibit, 0);
    tick(1); chk(inhibit == 1'b1 && hiz == 1'b0, "R1 inhibit after two edges", {inhibit, hiz}, 2);
    tick(1); chk(hiz == 1'b1 && asleep == 1'b0, "R2 entry cycle 1", {hiz, asleep}, 2);
    tick(1); chk(asleep == 1'b0, "R2 entry cycle 2", asleep, 0);
    tick(1); chk(asleep == 1'b1, "R2 asleep after entry", asleep, 1);
    tick(4);
    // R3: full exit
    sleep_req = 1'b0;
    tick(3); chk(asleep == 1'b0 && hiz == 1'b1, "R3 exit cycle 1", {asleep, hiz}, 1);
    tick(1); chk(hiz == 1'b1 && inhibit == 1'b1, "R3 exit cycle 2", {hiz, inhibit}, 3);
    tick(1); chk(hiz == 1'b0 && inhibit == 1'b0, "R3 awake after exit", {hiz, inhibit}, 0);
    tick(3);

    // R4: entry abort by one-cycle pulse
    sleep_req = 1'b1;
    tick(1);
    sleep_req = 1'b0;
    tick(2); chk(hiz == 1'b1, "R4 entry window reached", hiz, 1);
    tick(1); chk(hiz == 1'b0 && asleep == 1'b0, "R4 entry aborted to awake", {hiz, asleep}, 0);
    tick(4);

    // R4: exit abort
    sleep_req = 1'b1;
    tick(8); chk(asleep == 1'b1, "R4 asleep before exit abort", asleep, 1);
    sleep_req = 1'b0;
    tick(1);
    sleep_req = 1'b1;
    tick(2); chk(asleep == 1'b0 && hiz == 1'b1, "R4 exit window reached", {asleep, hiz}, 1);
    tick(1); chk(asleep == 1'b1, "R4 exit aborted back to asleep", asleep, 1);
    chk(viol == 1'b0, "R7 no flag without misuse", viol, 0);

    // R7: start strobe while asleep
    start = 1'b1;
    tick(1);
    start = 1'b0;
    chk(viol == 1'b1, "R7 start while asleep flags", viol, 1);
    sleep_req = 1'b0;
    tick(8);
    chk(viol == 1'b1 && hiz == 1'b0, "R9 flag sticky after wake", {viol, hiz}, 2);

    // R7 / R8 negatives, then R8 positive
    do_reset();
    tick(2);
    start = 1'b1; sel = 1'b1;
    tick(3);
    start = 1'b0;
    chk(viol == 1'b0, "R7 start and sel while awake ignored", viol, 0);
    sleep_req = 1'b1;
    tick(2); chk(viol == 1'b0, "R8 flag not yet set", viol, 0);
    tick(1); chk(viol == 1'b1, "R8 sel with request flags", viol, 1);
    sel = 1'b0; sleep_req = 1'b0;
    tick(10);
    chk(viol == 1'b1, "R9 flag held", viol, 1);
    do_reset();
    tick(1);
    chk(viol == 1'b0, "R9 reset clears flag", viol, 0);

    // mixed pattern
    for (int k = 0; k < 60; k++) begin
      sleep_req = ((k / 7) % 2 == 1);
      sel = (k % 11 == 3);
      start = (k % 13 == 5);
      tick(1);
    end
    sleep_req = 1'b0; sel = 1'b0; start = 1'b0;
    tick(6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule